// File: doc/BRIEF.md
# Byte-Wide SPI Master Engine with Sticky Write Collision

This block is the shift engine of a serial peripheral port on a microcontroller bus. When software writes a byte to the transfer buffer while the engine is idle, the engine runs one 8-bit exchange. Data leaves MSB first on `sdo_o` while `sck_o` toggles. At the same time the engine gathers 8 bits from `sdi_i` into the same shift register. When the exchange ends, the received byte is copied to a readable buffer, and both a buffer-full bit and an interrupt flag are raised.

Software sets three things. It picks the bit clock, which is either one of three fixed divisions of the system clock or half the rate of an external timer match pulse. It sets the idle level of the serial clock. It also chooses two timing options: whether output data changes on the leading (idle-to-active) edge or the trailing (active-to-idle) edge, and whether input is sampled at mid-bit or at end-of-bit. A buffer write made while a byte is still shifting is discarded. It also sets a collision flag that stays set until the module enable is dropped. Dropping the enable resets the whole engine.

Top module: `spi_master_core`

## Requirements
- R1: Out of reset, or while `en_i` is low, `busy_o`, `buf_full_o`, `irq_o`, `wcol_o` and `sdo_o` are 0, `rd_data_o` is 0, and `sck_o` follows `cpol_i` (the idle level) one cycle later.
- R2: A write (`wr_en_i`=1) while enabled and idle starts a transfer. `busy_o` is 1 from the next cycle. `sck_o` stays at the idle level at the write and for one full half-bit period after it. `sdo_o` shows bit 7 of the written byte from the first busy cycle.
- R3: `clk_sel_i` sets the half-bit period from the system clock. 0000 divides by DIV_FAST (half period DIV_FAST/2 cycles). 0001 divides by DIV_MID. Every value other than 0000, 0001 and 0011 divides by DIV_SLOW. In every case `sck_o` first leaves idle half-period + 1 clock edges after the write edge, and each SCK pulse has a 50% duty cycle.
- R4: `clk_sel_i` = 0011 selects the timer source. Each `tmr_match_i` pulse during a transfer is one half-bit boundary, so one SCK period spans two match pulses.
- R5: Every transfer gives exactly 8 active SCK pulses, 16 SCK transitions in all, and ends with `sck_o` at the idle level.
- R6: With `cke_i`=1, `sdo_o` changes on the active-to-idle SCK transition. With `cke_i`=0, it changes on the idle-to-active transition. Bits leave MSB first.
- R7: With `smp_i`=0, `sdi_i` is sampled at mid-bit. With `smp_i`=1, it is sampled at end-of-bit. In all four `cke_i`/`smp_i` combinations all 8 bits, bit 0 included, arrive in `rd_data_o` MSB first. When `cke_i`=0 and `smp_i`=1, one more half-bit follows the last SCK edge so that bit 0 can be captured.
- R8: A write while `busy_o`=1 is discarded and sets `wcol_o` on the next cycle. The running transfer keeps its data and still gives exactly 8 pulses.
- R9: `wcol_o` stays set through later transfers and clears only when `en_i` is low.
- R10: In the cycle after the last half-bit boundary, `busy_o` falls, `rd_data_o` holds the received byte, and `buf_full_o` and `irq_o` are both 1.
- R11: A `rd_en_i` pulse clears `buf_full_o` and leaves `irq_o` alone. An `irq_clr_i` pulse clears `irq_o` and leaves `buf_full_o` alone. A completion in the same cycle takes priority over either clear.
- R12: Pulling `en_i` low in the middle of a transfer aborts it on the next cycle, and every output returns to the R1 state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Module enable; low resets the engine |
| clk_sel_i | input | 4 | Bit-clock source select |
| cpol_i | input | 1 | SCK idle level |
| cke_i | input | 1 | 1: data changes on active-to-idle edge |
| smp_i | input | 1 | 1: sample at end of bit, 0: mid-bit |
| tmr_match_i | input | 1 | External timer match pulse |
| wr_en_i | input | 1 | Buffer write strobe |
| wr_data_i | input | 8 | Byte to transmit |
| rd_en_i | input | 1 | Buffer read strobe (clears buffer-full) |
| irq_clr_i | input | 1 | Write-one-to-clear for the interrupt flag |
| rd_data_o | output | 8 | Last received byte |
| busy_o | output | 1 | Transfer in progress |
| buf_full_o | output | 1 | Received byte waiting |
| irq_o | output | 1 | Transfer-done interrupt flag |
| wcol_o | output | 1 | Sticky write-collision flag |
| sck_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |

## Verification
The bench builds the block with its default dividers of 4, 16 and 64. A divide-by-64 byte therefore takes 512 cycles, and every clock-select path, including the default branch, fits in a short run. At these values the divide-by-4 half period is only two cycles, so a collision write can be placed a few cycles into a transfer, before the first SCK edge or close to it. The timer source is driven with a match every third cycle, which tests the half-rate path against a pulse pattern unrelated to the system-clock dividers. All four edge and sampling combinations are run with slave bytes whose bit 0 differs, so a lost or misplaced final sample appears in the received byte.

// File: rtl/spi_mst_pkg.sv
package spi_mst_pkg;

  typedef enum logic [1:0] {
    SRC_FAST,
    SRC_MID,
    SRC_SLOW,
    SRC_TMR
  } clk_src_e;

  localparam logic [3:0] SEL_FAST = 4'b0000;
  localparam logic [3:0] SEL_MID  = 4'b0001;
  localparam logic [3:0] SEL_TMR  = 4'b0011;

  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned EDGES    = 2 * BYTE_W;
  localparam int unsigned PH_W     = $clog2(EDGES + 2);

  function automatic clk_src_e decode_src(input logic [3:0] sel);
    case (sel)
      SEL_FAST: decode_src = SRC_FAST;
      SEL_MID:  decode_src = SRC_MID;
      SEL_TMR:  decode_src = SRC_TMR;
      default:  decode_src = SRC_SLOW;
    endcase
  endfunction

endpackage

// File: rtl/spi_baud_gen.sv
module spi_baud_gen
  import spi_mst_pkg::*;
#(
  parameter int unsigned DIV_FAST = 4,
  parameter int unsigned DIV_MID  = 16,
  parameter int unsigned DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic [3:0] sel,
  input  logic       tmr_match,
  output logic       tick
);

  localparam int unsigned CW = $clog2(DIV_SLOW / 2 + 1);
  localparam logic [CW-1:0] LAST_FAST = CW'(DIV_FAST / 2 - 1);
  localparam logic [CW-1:0] LAST_MID  = CW'(DIV_MID / 2 - 1);
  localparam logic [CW-1:0] LAST_SLOW = CW'(DIV_SLOW / 2 - 1);

  clk_src_e      src;
  logic [CW-1:0] last_cnt;
  logic [CW-1:0] cnt_q, cnt_n;

  always_comb begin
    src = decode_src(sel);
    case (src)
      SRC_FAST: last_cnt = LAST_FAST;
      SRC_MID:  last_cnt = LAST_MID;
      default:  last_cnt = LAST_SLOW;
    endcase
    if (src == SRC_TMR) begin
      tick  = run & tmr_match;
      cnt_n = '0;
    end else begin
      tick  = run & (cnt_q >= last_cnt);
      cnt_n = (!run || tick) ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_n;
  end

  p_tick_needs_run_r3: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> run);

  p_counter_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (src != SRC_TMR && run) |-> (cnt_q <= LAST_SLOW));

endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_mst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tick,
  input  logic              cpol,
  input  logic              cke,
  input  logic              smp,
  input  logic              sdi,
  output logic              busy,
  output logic              sck,
  output logic              sdo,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);

  localparam logic [PH_W-1:0] PH_ONE   = PH_W'(1);
  localparam logic [PH_W-1:0] PH_THREE = PH_W'(3);
  localparam logic [PH_W-1:0] PH_EDGES = PH_W'(EDGES);
  localparam logic [PH_W-1:0] PH_EXTRA = PH_W'(EDGES + 1);

  logic              busy_q, busy_n;
  logic [PH_W-1:0]   ph_q, ph_n;
  logic [BYTE_W-1:0] sreg_q, sreg_n;
  logic              cap_q, cap_n;
  logic              sck_q, sck_n;

  logic [PH_W-1:0]   k;
  logic [PH_W-1:0]   last_k;
  logic              odd, past_first, at_last, samp, shft, lsb_in;

  // Half-bit boundary decode
  always_comb begin
    k          = ph_q + PH_ONE;
    odd        = k[0];
    past_first = (k >= PH_THREE);
    last_k     = (!cke && smp) ? PH_EXTRA : PH_EDGES;
    at_last    = (k == last_k);
    if (cke) samp = smp ? ~odd : odd;
    else     samp = smp ? (odd & past_first) : ~odd;
    shft       = ~at_last & (cke ? ~odd : (odd & past_first));
    lsb_in     = samp ? sdi : cap_q;
    rx_byte    = {sreg_q[BYTE_W-2:0], lsb_in};
    done       = en & busy_q & tick & at_last;
  end

  // Next state
  always_comb begin
    busy_n = busy_q;
    ph_n   = ph_q;
    sreg_n = sreg_q;
    cap_n  = cap_q;
    sck_n  = sck_q;
    if (!en) begin
      busy_n = 1'b0;
      ph_n   = '0;
      sreg_n = '0;
      cap_n  = 1'b0;
      sck_n  = cpol;
    end else if (start) begin
      busy_n = 1'b1;
      ph_n   = '0;
      sreg_n = tx_data;
      cap_n  = 1'b0;
      sck_n  = cpol;
    end else if (busy_q) begin
      if (tick) begin
        ph_n = k;
        if (samp) cap_n = sdi;
        if (shft) sreg_n = {sreg_q[BYTE_W-2:0], lsb_in};
        sck_n = (k <= PH_EDGES) ? (cpol ^ odd) : cpol;
        if (at_last) busy_n = 1'b0;
      end
    end else begin
      sck_n = cpol;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      ph_q   <= '0;
      sreg_q <= '0;
      cap_q  <= 1'b0;
      sck_q  <= 1'b0;
    end else begin
      busy_q <= busy_n;
      ph_q   <= ph_n;
      sreg_q <= sreg_n;
      cap_q  <= cap_n;
      sck_q  <= sck_n;
    end
  end

  assign busy = busy_q;
  assign sck  = sck_q;
  assign sdo  = busy_q & sreg_q[BYTE_W-1];

  p_start_sck_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (busy && sck == $past(cpol)));

  p_phase_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (ph_q <= PH_EDGES));

  p_done_ends_r10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy);

  p_disabled_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!busy && !sdo && sck == $past(cpol)));

endmodule

// File: rtl/spi_status_regs.sv
module spi_status_regs
  import spi_mst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              collide,
  input  logic              done,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              rd_en,
  input  logic              irq_clr,
  output logic [BYTE_W-1:0] rd_data,
  output logic              buf_full,
  output logic              irq,
  output logic              wcol
);

  logic [BYTE_W-1:0] rbuf_q, rbuf_n;
  logic              bf_q, bf_n;
  logic              irq_q, irq_n;
  logic              wcol_q, wcol_n;

  always_comb begin
    rbuf_n = rbuf_q;
    bf_n   = bf_q;
    irq_n  = irq_q;
    wcol_n = wcol_q;
    if (!en) begin
      rbuf_n = '0;
      bf_n   = 1'b0;
      irq_n  = 1'b0;
      wcol_n = 1'b0;
    end else begin
      if (collide) wcol_n = 1'b1;
      if (done) begin
        rbuf_n = rx_byte;
        bf_n   = 1'b1;
        irq_n  = 1'b1;
      end else begin
        if (rd_en)   bf_n  = 1'b0;
        if (irq_clr) irq_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbuf_q <= '0;
      bf_q   <= 1'b0;
      irq_q  <= 1'b0;
      wcol_q <= 1'b0;
    end else begin
      rbuf_q <= rbuf_n;
      bf_q   <= bf_n;
      irq_q  <= irq_n;
      wcol_q <= wcol_n;
    end
  end

  assign rd_data  = rbuf_q;
  assign buf_full = bf_q;
  assign irq      = irq_q;
  assign wcol     = wcol_q;

  p_collide_flags_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && collide) |=> wcol);

  p_wcol_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wcol) |=> wcol);

  p_done_raises_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && done) |=> (buf_full && irq));

  p_read_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (en && rd_en && !done) |=> !buf_full);

endmodule

// File: rtl/spi_master_core.sv
module spi_master_core
  import spi_mst_pkg::*;
#(
  parameter int unsigned DIV_FAST = 4,
  parameter int unsigned DIV_MID  = 16,
  parameter int unsigned DIV_SLOW = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en_i,
  input  logic [3:0] clk_sel_i,
  input  logic       cpol_i,
  input  logic       cke_i,
  input  logic       smp_i,
  input  logic       tmr_match_i,
  input  logic       wr_en_i,
  input  logic [7:0] wr_data_i,
  input  logic       rd_en_i,
  input  logic       irq_clr_i,
  output logic [7:0] rd_data_o,
  output logic       busy_o,
  output logic       buf_full_o,
  output logic       irq_o,
  output logic       wcol_o,
  output logic       sck_o,
  output logic       sdo_o,
  input  logic       sdi_i
);

  logic       busy, tick, done, start, collide;
  logic [7:0] rx_byte;

  assign start   = en_i & wr_en_i & ~busy;
  assign collide = en_i & wr_en_i & busy;

  spi_baud_gen #(
    .DIV_FAST (DIV_FAST),
    .DIV_MID  (DIV_MID),
    .DIV_SLOW (DIV_SLOW)
  ) u_baud (
    .clk       (clk),
    .rst_n     (rst_n),
    .run       (busy),
    .sel       (clk_sel_i),
    .tmr_match (tmr_match_i),
    .tick      (tick)
  );

  spi_shift_engine u_eng (
    .clk     (clk),
    .rst_n   (rst_n),
    .en      (en_i),
    .start   (start),
    .tx_data (wr_data_i),
    .tick    (tick),
    .cpol    (cpol_i),
    .cke     (cke_i),
    .smp     (smp_i),
    .sdi     (sdi_i),
    .busy    (busy),
    .sck     (sck_o),
    .sdo     (sdo_o),
    .done    (done),
    .rx_byte (rx_byte)
  );

  spi_status_regs u_stat (
    .clk      (clk),
    .rst_n    (rst_n),
    .en       (en_i),
    .collide  (collide),
    .done     (done),
    .rx_byte  (rx_byte),
    .rd_en    (rd_en_i),
    .irq_clr  (irq_clr_i),
    .rd_data  (rd_data_o),
    .buf_full (buf_full_o),
    .irq      (irq_o),
    .wcol     (wcol_o)
  );

  assign busy_o = busy;

endmodule

// File: tb/sim_spi_master_core.sv
`timescale 1ns/1ps
module sim_spi_master_core;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [3:0] sel = 4'b0000;
  logic       cpol = 1'b0, cke = 1'b1, smp = 1'b0;
  logic       tmr_match = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       rd_en = 1'b0, irq_clr = 1'b0;
  logic       sdi = 1'b0;
  logic [7:0] rd_data;
  logic       busy, buf_full, irq, wcol, sck, sdo;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  spi_master_core u0 (
    .clk(clk), .rst_n(rst_n), .en_i(en), .clk_sel_i(sel), .cpol_i(cpol),
    .cke_i(cke), .smp_i(smp), .tmr_match_i(tmr_match), .wr_en_i(wr_en),
    .wr_data_i(wr_data), .rd_en_i(rd_en), .irq_clr_i(irq_clr),
    .rd_data_o(rd_data), .busy_o(busy), .buf_full_o(buf_full), .irq_o(irq),
    .wcol_o(wcol), .sck_o(sck), .sdo_o(sdo), .sdi_i(sdi)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Timer match source: one pulse every third cycle when enabled
  logic tmr_on = 1'b0;
  int   tcnt = 0;
  always @(negedge clk) begin
    tcnt++;
    tmr_match <= tmr_on && (tcnt % 3 == 0);
  end

  // Slave: presents slv bits according to SCK transitions seen so far
  logic [7:0] slv = 8'h00;
  int         nedge = 0;
  logic       sck_prev = 1'b0;
  always @(negedge clk) begin
    int j;
    if (!busy) nedge = 0;
    else if (sck != sck_prev) nedge++;
    sck_prev = sck;
    j = cke ? nedge / 2 : ((nedge == 0) ? 0 : (nedge - 1) / 2);
    if (j > 7) j = 7;
    sdi <= slv[7 - j];
  end

  // Behavioural reference model, advanced on each rising edge
  logic       m_busy, m_sck, m_bf, m_irq, m_wcol;
  logic [7:0] m_tx, m_rx, m_buf;
  int         m_k, m_cnt, m_shifts;

  function automatic int half_of(input logic [3:0] s);
    if (s == 4'b0000) return 2;
    if (s == 4'b0001) return 8;
    return 32;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy = 0; m_sck = 0; m_bf = 0; m_irq = 0; m_wcol = 0;
      m_tx = 0; m_rx = 0; m_buf = 0; m_k = 0; m_cnt = 0; m_shifts = 0;
    end else if (!en) begin
      m_busy = 0; m_sck = cpol; m_bf = 0; m_irq = 0; m_wcol = 0;
      m_tx = 0; m_rx = 0; m_buf = 0; m_k = 0; m_cnt = 0;
    end else begin
      if (irq_clr) m_irq = 0;
      if (rd_en) m_bf = 0;
      if (m_busy) begin
        logic tk;
        if (wr_en) m_wcol = 1;
        tk = 0;
        if (sel == 4'b0011) tk = tmr_match;
        else if (m_cnt == half_of(sel) - 1) begin tk = 1; m_cnt = 0; end
        else m_cnt++;
        if (tk) begin
          int rel, donek;
          logic mid, endb;
          m_k++;
          rel  = m_k - (cke ? 0 : 1);
          mid  = (rel > 0) && (rel % 2 == 1);
          endb = (rel > 0) && (rel % 2 == 0);
          if (smp ? endb : mid) m_rx = {m_rx[6:0], sdi};
          if (endb && m_shifts < 7) begin m_tx = m_tx << 1; m_shifts++; end
          m_sck = (m_k <= 16) ? (cpol ^ m_k[0]) : cpol;
          donek = (smp && !cke) ? 17 : 16;
          if (m_k == donek) begin
            m_busy = 0; m_buf = m_rx; m_bf = 1; m_irq = 1;
          end
        end
      end else if (wr_en) begin
        m_busy = 1; m_k = 0; m_cnt = 0; m_tx = wr_data; m_rx = 0;
        m_shifts = 0; m_sck = cpol;
      end else begin
        m_sck = cpol;
      end
    end
  end

  // Compare against the model on every cycle
  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (busy !== m_busy || sck !== m_sck || sdo !== (m_busy ? m_tx[7] : 1'b0) ||
          buf_full !== m_bf || irq !== m_irq || wcol !== m_wcol || rd_data !== m_buf) begin
        errors++;
        $display("FAIL R2/R5/R6/R10 model t=%0t busy %b/%b sck %b/%b sdo %b/%b bf %b/%b irq %b/%b wcol %b/%b rd %h/%h",
                 $time, busy, m_busy, sck, m_sck, sdo, (m_busy ? m_tx[7] : 1'b0),
                 buf_full, m_bf, irq, m_irq, wcol, m_wcol, rd_data, m_buf);
      end
    end
  end

  int pulses, first_mv;

  task automatic xfer(input logic [3:0] s, input logic p, input logic e, input logic m,
                      input logic [7:0] tx, input logic [7:0] sv, input bit collide);
    int n;
    logic prevs;
    @(negedge clk);
    sel = s; cpol = p; cke = e; smp = m; slv = sv;
    @(negedge clk);
    wr_en = 1; wr_data = tx;
    @(negedge clk);
    wr_en = 0;
    n = 1; pulses = 0; first_mv = 0; prevs = p;
    while (busy) begin
      if (sck != prevs && sck != p) pulses++;
      if (first_mv == 0 && sck != p) first_mv = n;
      prevs = sck;
      if (collide && n == 4) begin wr_en = 1; wr_data = ~tx; end
      else wr_en = 0;
      @(negedge clk);
      n++;
    end
    wr_en = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: reset / disabled state
    check("R1 busy", busy, 0);
    check("R1 sck idle", sck, 0);
    check("R1 sdo", sdo, 0);
    check("R1 flags", {buf_full, irq, wcol}, 0);
    check("R1 rd_data", rd_data, 0);
    cpol = 1;
    @(negedge clk);
    check("R1 sck follows cpol", sck, 1);
    cpol = 0;
    en = 1;

    // R2/R3/R5/R7/R10: the four edge/sample combinations on the fast divider
    for (int c = 0; c < 4; c++) begin
      logic [7:0] sv;
      sv = (c % 2 == 0) ? 8'hA5 : 8'h3C;
      xfer(4'b0000, c[0], c[1], c[0] ^ c[1], 8'h96 + 8'(c), sv, 0);
      check("R5 pulse count", pulses, 8);
      check("R2 R3 first SCK move fast", first_mv, 3);
      check("R7 received byte", rd_data, sv);
      check("R10 buffer full", buf_full, 1);
      check("R10 irq", irq, 1);
    end
    // R7: bit 0 set / cleared in all four combinations, end-of-bit included
    for (int c = 0; c < 4; c++) begin
      xfer(4'b0000, 1'b0, c[1], c[0], 8'h5A, 8'h81, 0);
      check("R7 bit0 one", rd_data, 8'h81);
      xfer(4'b0000, 1'b1, c[1], c[0], 8'hC3, 8'h7E, 0);
      check("R7 bit0 zero", rd_data, 8'h7E);
    end

    // R3: mid and slow dividers, default branch
    xfer(4'b0001, 0, 1, 0, 8'hF0, 8'h0F, 0);
    check("R3 first SCK move mid", first_mv, 9);
    check("R3 mid rx", rd_data, 8'h0F);
    xfer(4'b0010, 1, 0, 1, 8'h33, 8'hC6, 0);
    check("R3 first SCK move slow", first_mv, 33);
    check("R5 slow pulses", pulses, 8);
    xfer(4'b1011, 0, 0, 0, 8'h01, 8'h92, 0);
    check("R3 default select slow", first_mv, 33);
    check("R7 default select rx", rd_data, 8'h92);

    // R4: timer-match source
    tmr_on = 1;
    xfer(4'b0011, 0, 1, 1, 8'hE7, 8'h4B, 0);
    check("R4 timer pulses", pulses, 8);
    check("R4 timer rx", rd_data, 8'h4B);
    tmr_on = 0;

    // R11: separate clears
    @(negedge clk); rd_en = 1;
    @(negedge clk); rd_en = 0;
    check("R11 read clears buf_full", buf_full, 0);
    check("R11 read keeps irq", irq, 1);
    irq_clr = 1;
    @(negedge clk); irq_clr = 0;
    check("R11 w1c clears irq", irq, 0);
    check("R11 w1c keeps buf_full", buf_full, 0);

    // R8: collision write ignored
    check("R8 wcol clear before", wcol, 0);
    xfer(4'b0000, 0, 1, 0, 8'hB4, 8'h6D, 1);
    check("R8 wcol set", wcol, 1);
    check("R8 pulses unaffected", pulses, 8);
    check("R8 rx unaffected", rd_data, 8'h6D);
    // R9: sticky across a clean transfer
    xfer(4'b0000, 0, 0, 1, 8'h2D, 8'hD2, 0);
    check("R9 wcol sticky", wcol, 1);
    check("R9 next transfer ok", rd_data, 8'hD2);
    @(negedge clk); en = 0;
    @(negedge clk);
    check("R9 wcol cleared by disable", wcol, 0);
    en = 1;

    // R12: abort mid-transfer
    cpol = 1; sel = 4'b0001;
    @(negedge clk); wr_en = 1; wr_data = 8'hFF;
    @(negedge clk); wr_en = 0;
    repeat (20) @(negedge clk);
    check("R12 busy before abort", busy, 1);
    en = 0;
    @(negedge clk);
    check("R12 busy aborted", busy, 0);
    check("R12 sck idle", sck, 1);
    check("R12 sdo low", sdo, 0);
    check("R12 flags", {buf_full, irq, wcol}, 0);
    en = 1;
    repeat (3) @(negedge clk);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule